// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands in the execute stage of a five-stage in-order pipeline, whether the operand is taken from the register file or bypassed from a later stage. It compares the operand's source register number with the destination register numbers held in the two pipeline registers downstream. The nearer one holds the execute/memory result. The farther one holds the memory/writeback value. A match only counts when that stage's write enable is set and its destination is not register zero. When both stages match, the nearer and more recent result wins.

Each operand's select code is produced by combinational logic, and so is the selected operand value. Both are then captured in a small output register, so the unit can be tested on a clock edge. A pipeline would capture the same values as the ALU input latch. A write and a read of the same register in one cycle is not handled here. The register file already returns the new value in that case.

Top module: `opfwd_unit`

## Requirements
- R1: While reset is asserted (rst_n low), both select outputs read 2'b00 and both operand outputs read zero.
- R2: If the near stage has its write enable set, a non-zero destination, and a destination equal to an operand's source register, then that operand's select reads 2'b10 and its value equals the near-stage result.
- R3: If only the far stage has its write enable set, a non-zero destination, and a destination equal to an operand's source register, then that operand's select reads 2'b01 and its value equals the far-stage value.
- R4: An operand whose source matches no qualifying stage has select 2'b00, and its value equals its register-file read value.
- R5: A stage whose write enable is low is never forwarded from, even when its destination equals the source.
- R6: A destination of register zero is never forwarded from, even with its write enable set.
- R7: When both stages qualify for the same operand, select 2'b10 and the near-stage result are chosen.
- R8: Operand A compares only against source 1 and operand B only against source 2. The two operands may select different stages in the same cycle.
- R9: The select code 2'b11 is never output.
- R10: Outputs change on the rising clock edge that follows a change of the inputs. They hold the decision made from the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src1_reg_i | input | REG_W | Source register number for operand A |
| src2_reg_i | input | REG_W | Source register number for operand B |
| rf_a_i | input | DATA_W | Register-file read value for operand A |
| rf_b_i | input | DATA_W | Register-file read value for operand B |
| near_dst_i | input | REG_W | Destination register in the execute/memory stage |
| near_wen_i | input | 1 | Register-write enable in the execute/memory stage |
| near_res_i | input | DATA_W | Result held in the execute/memory stage |
| far_dst_i | input | REG_W | Destination register in the memory/writeback stage |
| far_wen_i | input | 1 | Register-write enable in the memory/writeback stage |
| far_res_i | input | DATA_W | Value held in the memory/writeback stage |
| sel_a_o | output | 2 | Registered select for operand A (00 file, 01 far, 10 near) |
| sel_b_o | output | 2 | Registered select for operand B (00 file, 01 far, 10 near) |
| op_a_o | output | DATA_W | Registered operand A value |
| op_b_o | output | DATA_W | Registered operand B value |

## Verification
The properties assume that every input is a known value at each rising edge once reset is released. They also assume that a given set of inputs is judged only by the outputs one edge later. The bench drives all inputs on the falling edge and never leaves any of them undriven, so every rising edge sees stable, defined values. The bench uses register numbers across the whole 5-bit range, including zero and 31. It includes cases where a destination matches while its write enable is low, which lets the properties that gate on the enables and on register zero fire in both directions.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF   = 2'b00,
    FWD_FAR  = 2'b01,
    FWD_NEAR = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/opfwd_select.sv
module opfwd_select
  import opfwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] near_dst_i,
  input  logic             near_wen_i,
  input  logic [REG_W-1:0] far_dst_i,
  input  logic             far_wen_i,
  output fwd_sel_e         sel_o,
  output logic             near_hit_o,
  output logic             far_hit_o
);
  // A stage qualifies only if it writes a real (non-zero) register matching src
  function automatic logic stage_hit(input logic wen,
                                     input logic [REG_W-1:0] dst,
                                     input logic [REG_W-1:0] src);
    return wen && (dst != '0) && (dst == src);
  endfunction

  assign near_hit_o = stage_hit(near_wen_i, near_dst_i, src_i);
  assign far_hit_o  = stage_hit(far_wen_i, far_dst_i, src_i);

  // Nearer stage holds the more recent write and takes priority
  always_comb begin
    if (near_hit_o)     sel_o = FWD_NEAR;
    else if (far_hit_o) sel_o = FWD_FAR;
    else                sel_o = FWD_RF;
  end
endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
  import opfwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] near_i,
  input  logic [DATA_W-1:0] far_i,
  output logic [DATA_W-1:0] val_o
);
  always_comb begin
    unique case (sel_i)
      FWD_NEAR: val_o = near_i;
      FWD_FAR:  val_o = far_i;
      default:  val_o = rf_i;
    endcase
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  src1_reg_i,
  input  logic [REG_W-1:0]  src2_reg_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [REG_W-1:0]  near_dst_i,
  input  logic              near_wen_i,
  input  logic [DATA_W-1:0] near_res_i,
  input  logic [REG_W-1:0]  far_dst_i,
  input  logic              far_wen_i,
  input  logic [DATA_W-1:0] far_res_i,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o
);
  localparam int NUM_OPS = 2;

  logic [REG_W-1:0]  src_reg [NUM_OPS];
  logic [DATA_W-1:0] rf_val  [NUM_OPS];
  fwd_sel_e          sel_nxt [NUM_OPS];
  logic [DATA_W-1:0] op_nxt  [NUM_OPS];
  logic [SEL_W-1:0]  sel_q   [NUM_OPS];
  logic [DATA_W-1:0] op_q    [NUM_OPS];

  // Named per-operand match events, visible to the bound checker
  logic [NUM_OPS-1:0] near_hit;
  logic [NUM_OPS-1:0] far_hit;

  assign src_reg[0] = src1_reg_i;
  assign src_reg[1] = src2_reg_i;
  assign rf_val[0]  = rf_a_i;
  assign rf_val[1]  = rf_b_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    opfwd_select #(.REG_W(REG_W)) sel_i (
      .src_i      (src_reg[g]),
      .near_dst_i (near_dst_i),
      .near_wen_i (near_wen_i),
      .far_dst_i  (far_dst_i),
      .far_wen_i  (far_wen_i),
      .sel_o      (sel_nxt[g]),
      .near_hit_o (near_hit[g]),
      .far_hit_o  (far_hit[g])
    );

    opfwd_mux #(.DATA_W(DATA_W)) mux_i (
      .sel_i  (sel_nxt[g]),
      .rf_i   (rf_val[g]),
      .near_i (near_res_i),
      .far_i  (far_res_i),
      .val_o  (op_nxt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= FWD_RF;
        op_q[g]  <= '0;
      end else begin
        sel_q[g] <= sel_nxt[g];
        op_q[g]  <= op_nxt[g];
      end
    end
  end

  assign sel_a_o = sel_q[0];
  assign sel_b_o = sel_q[1];
  assign op_a_o  = op_q[0];
  assign op_b_o  = op_q[1];
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  src1_reg_i,
  input logic [REG_W-1:0]  src2_reg_i,
  input logic [DATA_W-1:0] rf_a_i,
  input logic [DATA_W-1:0] rf_b_i,
  input logic [REG_W-1:0]  near_dst_i,
  input logic              near_wen_i,
  input logic [DATA_W-1:0] near_res_i,
  input logic [REG_W-1:0]  far_dst_i,
  input logic              far_wen_i,
  input logic [DATA_W-1:0] far_res_i,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o,
  input logic [DATA_W-1:0] op_a_o,
  input logic [DATA_W-1:0] op_b_o,
  input logic [1:0]        near_hit,
  input logic [1:0]        far_hit
);
  // R9
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_o != 2'b11) && (sel_b_o != 2'b11));

  // R2
  near_bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (near_wen_i && (near_dst_i != '0) && (near_dst_i == src1_reg_i))
    |=> (sel_a_o == 2'b10) && (op_a_o == $past(near_res_i)));

  // R3
  far_bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (far_hit[1] && !near_hit[1])
    |=> (sel_b_o == 2'b01) && (op_b_o == $past(far_res_i)));

  // R5
  no_wen_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!near_wen_i && !far_wen_i)
    |=> (sel_a_o == 2'b00) && (sel_b_o == 2'b00) && (op_a_o == $past(rf_a_i)));

  // R6
  zero_dst_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((near_dst_i == '0) && (far_dst_i == '0))
    |=> (sel_a_o == 2'b00) && (op_b_o == $past(rf_b_i)));

  // R8
  operand_b_uses_src2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!near_hit[1] && !far_hit[1])
    |=> (op_b_o == $past(rf_b_i)));
endmodule

bind opfwd_unit opfwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .src1_reg_i (src1_reg_i),
  .src2_reg_i (src2_reg_i),
  .rf_a_i     (rf_a_i),
  .rf_b_i     (rf_b_i),
  .near_dst_i (near_dst_i),
  .near_wen_i (near_wen_i),
  .near_res_i (near_res_i),
  .far_dst_i  (far_dst_i),
  .far_wen_i  (far_wen_i),
  .far_res_i  (far_res_i),
  .sel_a_o    (sel_a_o),
  .sel_b_o    (sel_b_o),
  .op_a_o     (op_a_o),
  .op_b_o     (op_b_o),
  .near_hit   (near_hit),
  .far_hit    (far_hit)
);

// File: tb/opfwd_unit_tb.sv
`timescale 1ns/1ps
module opfwd_unit_tb_top;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int NVEC   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [REG_W-1:0]  src1_reg_i = '0, src2_reg_i = '0;
  logic [DATA_W-1:0] rf_a_i = '0, rf_b_i = '0;
  logic [REG_W-1:0]  near_dst_i = '0, far_dst_i = '0;
  logic              near_wen_i = 1'b0, far_wen_i = 1'b0;
  logic [DATA_W-1:0] near_res_i = '0, far_res_i = '0;
  logic [1:0]        sel_a_o, sel_b_o;
  logic [DATA_W-1:0] op_a_o, op_b_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  opfwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) dut_i (.*);

  // {src1, src2, near_dst, near_wen, far_dst, far_wen, exp_sel_a, exp_sel_b}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00},
    {5'd7,  5'd8,  5'd2,  1'b1, 5'd8,  1'b1, 2'b00, 2'b01},
    {5'd5,  5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 2'b10, 2'b10},
    {5'd6,  5'd6,  5'd6,  1'b0, 5'd6,  1'b1, 2'b01, 2'b01},
    {5'd6,  5'd6,  5'd6,  1'b0, 5'd6,  1'b0, 2'b00, 2'b00},
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},
    {5'd0,  5'd12, 5'd0,  1'b1, 5'd12, 1'b1, 2'b00, 2'b01},
    {5'd10, 5'd11, 5'd11, 1'b1, 5'd10, 1'b1, 2'b01, 2'b10},
    {5'd31, 5'd31, 5'd31, 1'b1, 5'd1,  1'b1, 2'b10, 2'b10},
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00},
    {5'd13, 5'd14, 5'd14, 1'b1, 5'd13, 1'b1, 2'b01, 2'b10},
    {5'd20, 5'd20, 5'd21, 1'b1, 5'd20, 1'b0, 2'b00, 2'b00}
  };

  function automatic logic [DATA_W-1:0] expect_val(input logic [1:0] s,
      input logic [DATA_W-1:0] rf, input logic [DATA_W-1:0] nr,
      input logic [DATA_W-1:0] fr);
    return (s == 2'b10) ? nr : ((s == 2'b01) ? fr : rf);
  endfunction

  function automatic string tag_of(input logic [1:0] s);
    return (s == 2'b10) ? "R2" : ((s == 2'b01) ? "R3" : "R4");
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] s1, input logic [4:0] s2,
                       input logic [4:0] nd, input logic nw,
                       input logic [4:0] fd, input logic fw,
                       input logic [DATA_W-1:0] base);
    src1_reg_i = s1; src2_reg_i = s2;
    near_dst_i = nd; near_wen_i = nw;
    far_dst_i  = fd; far_wen_i  = fw;
    rf_a_i     = 32'hA000_0000 + base;
    rf_b_i     = 32'hB000_0000 + base;
    near_res_i = 32'hC000_0000 + base;
    far_res_i  = 32'hD000_0000 + base;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs at zero even with forwarding-worthy inputs
    drive(5'd3, 5'd3, 5'd3, 1'b1, 5'd3, 1'b1, 32'h55);
    repeat (3) @(negedge clk);
    check("R1 sel_a", {30'd0, sel_a_o}, 32'd0);
    check("R1 sel_b", {30'd0, sel_b_o}, 32'd0);
    check("R1 op_a", op_a_o, 32'd0);
    check("R1 op_b", op_b_o, 32'd0);
    rst_n = 1'b1;

    // Vector table: drive on falling edge, sample at the next falling edge
    for (int k = 0; k < NVEC; k++) begin
      logic [25:0] v;
      v = VEC[k];
      @(negedge clk);
      drive(v[25:21], v[20:16], v[15:11], v[10], v[9:5], v[4], 32'(k));
      @(negedge clk);
      check({tag_of(v[3:2]), " R9 sel_a"}, {30'd0, sel_a_o}, {30'd0, v[3:2]});
      check({tag_of(v[1:0]), " R9 sel_b"}, {30'd0, sel_b_o}, {30'd0, v[1:0]});
      check({tag_of(v[3:2]), " op_a"}, op_a_o,
            expect_val(v[3:2], rf_a_i, near_res_i, far_res_i));
      check({tag_of(v[1:0]), " op_b"}, op_b_o,
            expect_val(v[1:0], rf_b_i, near_res_i, far_res_i));
    end

    // R10: new inputs are not visible before the next rising edge
    @(negedge clk);
    drive(5'd9, 5'd1, 5'd9, 1'b1, 5'd2, 1'b1, 32'h77);
    #1;
    check("R10 before edge sel_a", {30'd0, sel_a_o}, 32'd0);
    @(negedge clk);
    check("R10 after edge sel_a", {30'd0, sel_a_o}, 32'd2);

    // R7: both stages match operand A; near result wins
    drive(5'd17, 5'd0, 5'd17, 1'b1, 5'd17, 1'b1, 32'h99);
    @(negedge clk);
    check("R7 op_a", op_a_o, 32'hC000_0099);

    // R5: matching destinations but both write enables low
    drive(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 32'h31);
    @(negedge clk);
    check("R5 op_a", op_a_o, 32'hA000_0031);
    check("R5 op_b", op_b_o, 32'hB000_0031);

    // R6: register zero with both enables set
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 32'h42);
    @(negedge clk);
    check("R6 op_a", op_a_o, 32'hA000_0042);
    check("R6 op_b", op_b_o, 32'hB000_0042);

    // R8: A from far stage via src1, B from near stage via src2, same cycle
    drive(5'd25, 5'd26, 5'd26, 1'b1, 5'd25, 1'b1, 32'h63);
    @(negedge clk);
    check("R8 op_a", op_a_o, 32'hD000_0063);
    check("R8 op_b", op_b_o, 32'hC000_0063);

    finish_run();
  end
endmodule